// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Tag Directory

This block keeps the tags and per-set state of a two-way set-associative cache that writes back dirty lines and allocates on write misses. It holds no line data and drives no memory bus: it decides, for each request, whether the line is resident, which way serves or receives it, and whether the line being displaced must first be written back. It then updates its stored state to match that decision.

A request is a load/store flag and a 32-bit address. It is accepted with a valid/ready handshake. The address is split into a tag field (upper bits), a set index (middle bits) and a byte offset (low bits). The widths of these fields are parameters. The selected set is examined and a one-cycle result strobe is returned, carrying the hit flag, the way, the write-back flag, the displaced tag, and the index and offset of the request. Every tag, valid, dirty and replacement update is committed on the same clock edge that loads the result. Two running totals, one of hits and one of misses, are presented continuously.

The control is a two-state machine. `S_IDLE` holds the ready signal high, and the transition *accept* (valid and ready both high) moves it to `S_RESOLVE`. In `S_RESOLVE` the set is looked up, the decision is made, and on the next edge the state is written back and the result is registered. The transition *commit* then returns it unconditionally to `S_IDLE`.

Top module: `twoway_tag_dir`

## Requirements
- R1: After reset every way of every set is invalid and clean, every stored tag is 0, the replacement bit of every set is 0, both totals are 0, `req_ready` is 1 and `res_valid` is 0.
- R2: A request hits a way only if that way is valid and its stored tag equals the request tag. A request whose tag matches only an invalid way is a miss.
- R3: After a hit, the replacement bit of the set names the other way: it becomes 1 after a hit in way 0 and 0 after a hit in way 1.
- R4: A store hit marks the hit way dirty. A load hit leaves that way's dirty bit as it was.
- R5: On a miss, the way filled (`res_way`) is the way named by the set's replacement bit: way 0 when the bit is 0, way 1 when it is 1.
- R6: `res_wb` is 1 only on a miss whose victim way was valid and dirty. It is 0 on every hit.
- R7: On a miss, the victim way takes the request tag and becomes valid. It becomes dirty for a store and clean for a load, and the replacement bit then names the other way. `res_victim_tag` carries the tag the victim way held before the fill on a miss, and 0 on a hit.
- R8: The offset is the low OFF_W address bits, the index is the next IDX_W bits, and the tag is the top TAG_W bits. `res_index` and `res_offset` return the index and offset of the request.
- R9: Each result increments exactly one of `hit_count` or `miss_count`, and the new totals are visible in the same cycle as the result strobe.
- R10: After the accepting edge, `req_ready` is 0 for one cycle. `res_valid` is high for exactly one cycle, starting at the edge after the accepting edge.
- R11: A request to the same set issued immediately after the previous result sees that result's state updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory can accept a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Request address |
| res_valid | output | 1 | Result strobe, one cycle |
| res_hit | output | 1 | 1 = hit, 0 = miss |
| res_way | output | 1 | Way hit or filled |
| res_wb | output | 1 | Victim must be written back |
| res_victim_tag | output | TAG_W | Tag held by the victim before the fill (0 on a hit) |
| res_index | output | IDX_W | Set index of the request |
| res_offset | output | OFF_W | Offset of the request |
| hit_count | output | CNT_W | Running total of hits |
| miss_count | output | CNT_W | Running total of misses |

## Verification
The bench builds the directory with TAG_W = 26, IDX_W = 2 and OFF_W = 4. With only four sets and tags drawn from a pool of six values, the random stream keeps revisiting the same sets. This makes hits on both ways, evictions of dirty and clean victims, and alternating replacement bits frequent rather than rare. The directed opening exercises a tag of 0 in a fresh set, a store hit followed by a load hit, and a dirty eviction before the random phase starts.

// File: rtl/tdir_pkg.sv
package tdir_pkg;

    typedef enum logic [0:0] {
        S_IDLE    = 1'b0,
        S_RESOLVE = 1'b1
    } dir_state_e;

    // Per-set state word: [4] replacement, [3] valid w0, [2] dirty w0,
    // [1] valid w1, [0] dirty w1.
    localparam int META_W  = 5;
    localparam int LRU_BIT = 4;

    function automatic int vld_pos(input logic way);
        return way ? 1 : 3;
    endfunction

    function automatic int drt_pos(input logic way);
        return way ? 0 : 2;
    endfunction

endpackage

// File: rtl/tdir_split.sv
module tdir_split #(
    parameter int TAG_W = 24,
    parameter int IDX_W = 4,
    parameter int OFF_W = 4
) (
    input  logic [TAG_W+IDX_W+OFF_W-1:0] addr,
    output logic [TAG_W-1:0]             tag,
    output logic [IDX_W-1:0]             idx,
    output logic [OFF_W-1:0]             off
);
    localparam int IDX_LO = OFF_W;
    localparam int TAG_LO = OFF_W + IDX_W;

    assign off = addr[OFF_W-1:0];
    assign idx = addr[IDX_LO +: IDX_W];
    assign tag = addr[TAG_LO +: TAG_W];
endmodule

// File: rtl/tdir_store.sv
module tdir_store
    import tdir_pkg::*;
#(
    parameter int TAG_W = 24,
    parameter int IDX_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [1:0][TAG_W-1:0]  rd_tags,
    output logic [META_W-1:0]      rd_meta,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_fill,
    input  logic                   wr_way,
    input  logic [TAG_W-1:0]       wr_tag,
    input  logic [META_W-1:0]      wr_meta
);
    localparam int SETS = 1 << IDX_W;

    logic [META_W-1:0] meta_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) meta_q[s] <= '0;
        end else if (wr_en) begin
            meta_q[wr_idx] <= wr_meta;
        end
    end

    assign rd_meta = meta_q[rd_idx];

    for (genvar w = 0; w < 2; w++) begin : g_way
        logic [TAG_W-1:0] tag_q [SETS];
        logic             sel;

        assign sel = wr_en && wr_fill && (wr_way == (w != 0));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
            end else if (sel) begin
                tag_q[wr_idx] <= wr_tag;
            end
        end

        assign rd_tags[w] = tag_q[rd_idx];
    end
endmodule

// File: rtl/tdir_decide.sv
module tdir_decide
    import tdir_pkg::*;
#(
    parameter int TAG_W = 24
) (
    input  logic [TAG_W-1:0]       req_tag,
    input  logic                   is_store,
    input  logic [1:0][TAG_W-1:0]  set_tags,
    input  logic [META_W-1:0]      meta,
    output logic                   hit,
    output logic                   way,
    output logic                   wb,
    output logic [TAG_W-1:0]       victim_tag,
    output logic                   fill,
    output logic [META_W-1:0]      next_meta
);
    logic [1:0] match;
    logic       hit_way;
    logic       victim;

    for (genvar w = 0; w < 2; w++) begin : g_cmp
        assign match[w] = meta[vld_pos(w != 0)] && (set_tags[w] == req_tag);
    end

    assign hit     = |match;
    assign hit_way = !match[0];
    assign victim  = meta[LRU_BIT];

    always_comb begin
        next_meta  = meta;
        wb         = 1'b0;
        victim_tag = '0;
        fill       = 1'b0;
        if (hit) begin
            way                = hit_way;
            next_meta[LRU_BIT] = !hit_way;
            if (is_store) next_meta[drt_pos(hit_way)] = 1'b1;
        end else begin
            way                        = victim;
            fill                       = 1'b1;
            wb                         = meta[vld_pos(victim)] && meta[drt_pos(victim)];
            victim_tag                 = set_tags[victim];
            next_meta[vld_pos(victim)] = 1'b1;
            next_meta[drt_pos(victim)] = is_store;
            next_meta[LRU_BIT]         = !victim;
        end
    end
endmodule

// File: rtl/twoway_tag_dir.sv
module twoway_tag_dir
    import tdir_pkg::*;
#(
    parameter int TAG_W = 24,
    parameter int IDX_W = 4,
    parameter int OFF_W = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_store,
    input  logic [31:0]      req_addr,
    output logic             res_valid,
    output logic             res_hit,
    output logic             res_way,
    output logic             res_wb,
    output logic [TAG_W-1:0] res_victim_tag,
    output logic [IDX_W-1:0] res_index,
    output logic [OFF_W-1:0] res_offset,
    output logic [CNT_W-1:0] hit_count,
    output logic [CNT_W-1:0] miss_count
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    initial begin
        assert (ADDR_W == 32 && TAG_W >= 1 && IDX_W >= 1 && IDX_W <= 9 && OFF_W >= 1)
            else $error("field widths must be at least 1 and sum to 32");
    end

    dir_state_e state_q, state_d;
    logic       store_q;
    logic [31:0] addr_q;
    logic       accept;

    logic [TAG_W-1:0]      a_tag;
    logic [IDX_W-1:0]      a_idx;
    logic [OFF_W-1:0]      a_off;
    logic [1:0][TAG_W-1:0] rd_tags;
    logic [META_W-1:0]     rd_meta;
    logic                  dec_hit, dec_way, dec_wb, dec_fill;
    logic [TAG_W-1:0]      dec_vtag;
    logic [META_W-1:0]     dec_meta;
    logic                  commit;

    assign accept = req_valid && req_ready;
    assign commit = (state_q == S_RESOLVE);

    tdir_split #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_split (
        .addr (addr_q),
        .tag  (a_tag),
        .idx  (a_idx),
        .off  (a_off)
    );

    tdir_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (a_idx),
        .rd_tags (rd_tags),
        .rd_meta (rd_meta),
        .wr_en   (commit),
        .wr_idx  (a_idx),
        .wr_fill (dec_fill),
        .wr_way  (dec_way),
        .wr_tag  (a_tag),
        .wr_meta (dec_meta)
    );

    tdir_decide #(.TAG_W(TAG_W)) u_decide (
        .req_tag    (a_tag),
        .is_store   (store_q),
        .set_tags   (rd_tags),
        .meta       (rd_meta),
        .hit        (dec_hit),
        .way        (dec_way),
        .wb         (dec_wb),
        .victim_tag (dec_vtag),
        .fill       (dec_fill),
        .next_meta  (dec_meta)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (accept) state_d = S_RESOLVE;
            S_RESOLVE: state_d = S_IDLE;
        endcase
    end

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            store_q <= 1'b0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                store_q <= req_store;
                addr_q  <= req_addr;
            end
        end
    end

    assign req_ready = (state_q == S_IDLE);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid      <= 1'b0;
            res_hit        <= 1'b0;
            res_way        <= 1'b0;
            res_wb         <= 1'b0;
            res_victim_tag <= '0;
            res_index      <= '0;
            res_offset     <= '0;
            hit_count      <= '0;
            miss_count     <= '0;
        end else begin
            res_valid <= commit;
            if (commit) begin
                res_hit        <= dec_hit;
                res_way        <= dec_way;
                res_wb         <= dec_wb;
                res_victim_tag <= dec_vtag;
                res_index      <= a_idx;
                res_offset     <= a_off;
                if (dec_hit) hit_count  <= hit_count + CNT_W'(1);
                else         miss_count <= miss_count + CNT_W'(1);
            end
        end
    end

    // Checks on the handshake, totals and committed set state
    p_accept_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);
    p_result_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ##1 res_valid);
    p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    p_hit_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_hit) |-> (hit_count == $past(hit_count) + CNT_W'(1)
                                    && miss_count == $past(miss_count)));
    p_miss_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (miss_count == $past(miss_count) + CNT_W'(1)
                                     && hit_count == $past(hit_count)));
    p_wb_only_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_wb) |-> !res_hit);
    p_hit_lru_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && dec_hit) |=> (rd_meta[LRU_BIT] != res_way));
    p_store_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && dec_hit && store_q) |=> rd_meta[drt_pos(res_way)]);
    p_victim_lru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !dec_hit) |=> (res_way == $past(rd_meta[LRU_BIT])));
    p_fill_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !dec_hit) |=> (rd_meta[vld_pos(res_way)]
                                  && rd_tags[res_way] == a_tag
                                  && rd_meta[LRU_BIT] != res_way));
endmodule

// File: tb/tb_twoway_tag_dir.sv
`timescale 1ns/100ps
module tb_twoway_tag_dir;
    localparam int TAG_W = 26;
    localparam int IDX_W = 2;
    localparam int OFF_W = 4;
    localparam int CNT_W = 32;
    localparam int SETS  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_store = 1'b0;
    logic [31:0] req_addr = '0;
    logic res_valid, res_hit, res_way, res_wb;
    logic [TAG_W-1:0] res_victim_tag;
    logic [IDX_W-1:0] res_index;
    logic [OFF_W-1:0] res_offset;
    logic [CNT_W-1:0] hit_count, miss_count;

    always #2.5 clk = ~clk;

    twoway_tag_dir #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_store(req_store), .req_addr(req_addr), .res_valid(res_valid),
        .res_hit(res_hit), .res_way(res_way), .res_wb(res_wb),
        .res_victim_tag(res_victim_tag), .res_index(res_index), .res_offset(res_offset),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [TAG_W-1:0] m_tag [SETS][2];
    logic             m_vld [SETS][2];
    logic             m_drt [SETS][2];
    logic             m_lru [SETS];
    int               m_hits = 0;
    int               m_miss = 0;

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] mkaddr(input logic [TAG_W-1:0] t,
                                           input logic [IDX_W-1:0] i,
                                           input logic [OFF_W-1:0] o);
        return {t, i, o};
    endfunction

    function automatic logic model_hit(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t);
        return (m_vld[i][0] && m_tag[i][0] == t) || (m_vld[i][1] && m_tag[i][1] == t);
    endfunction

    function automatic logic model_way(input logic [IDX_W-1:0] i, input logic [TAG_W-1:0] t);
        if (m_vld[i][0] && m_tag[i][0] == t) return 1'b0;
        if (m_vld[i][1] && m_tag[i][1] == t) return 1'b1;
        return m_lru[i];
    endfunction

    task automatic do_req(input string ctx, input logic st, input logic [TAG_W-1:0] t,
                          input logic [IDX_W-1:0] i, input logic [OFF_W-1:0] o);
        logic e_hit, e_way, e_wb;
        logic [TAG_W-1:0] e_vt;
        e_hit = model_hit(i, t);
        e_way = model_way(i, t);
        e_wb  = !e_hit && m_vld[i][e_way] && m_drt[i][e_way];
        e_vt  = e_hit ? '0 : m_tag[i][e_way];
        // model update
        if (e_hit) begin
            if (st) m_drt[i][e_way] = 1'b1;
            m_hits++;
        end else begin
            m_tag[i][e_way] = t;
            m_vld[i][e_way] = 1'b1;
            m_drt[i][e_way] = st;
            m_miss++;
        end
        m_lru[i] = !e_way;

        req_valid = 1'b1;
        req_store = st;
        req_addr  = mkaddr(t, i, o);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check({ctx, " R10 ready low after accept"}, 64'(req_ready), 64'd0);
        check({ctx, " R10 no early result"}, 64'(res_valid), 64'd0);
        @(negedge clk);
        check({ctx, " R10 result strobe"}, 64'(res_valid), 64'd1);
        check({ctx, " R2 hit flag"}, 64'(res_hit), 64'(e_hit));
        check({ctx, " R5 way"}, 64'(res_way), 64'(e_way));
        check({ctx, " R6 write-back"}, 64'(res_wb), 64'(e_wb));
        check({ctx, " R7 victim tag"}, 64'(res_victim_tag), 64'(e_vt));
        check({ctx, " R8 index"}, 64'(res_index), 64'(i));
        check({ctx, " R8 offset"}, 64'(res_offset), 64'(o));
        check({ctx, " R9 hit total"}, 64'(hit_count), 64'(m_hits));
        check({ctx, " R9 miss total"}, 64'(miss_count), 64'(m_miss));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(5.0 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_0229));
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_tag[s][w] = '0;
                m_vld[s][w] = 1'b0;
                m_drt[s][w] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check("R1 ready after reset", 64'(req_ready), 64'd1);
        check("R1 no result after reset", 64'(res_valid), 64'd0);
        check("R1 hit total zero", 64'(hit_count), 64'd0);
        check("R1 miss total zero", 64'(miss_count), 64'd0);

        // R1/R2: tag 0 matches the cleared stored tag but the way is invalid
        do_req("R1 tag0 fresh set", 1'b0, '0, 2'd3, 4'h0);
        do_req("R1 second way fill", 1'b0, 26'h5, 2'd1, 4'h2);
        do_req("R7 fill way1", 1'b0, 26'h9, 2'd1, 4'h3);
        do_req("R4 store hit way0", 1'b1, 26'h5, 2'd1, 4'hF);
        do_req("R3 load hit way1", 1'b0, 26'h9, 2'd1, 4'h1);
        do_req("R4 load hit keeps dirty", 1'b0, 26'h5, 2'd1, 4'h4);
        do_req("R3 hit way1 again", 1'b0, 26'h9, 2'd1, 4'h0);
        // victim is way0 (dirty) -> write-back
        do_req("R6 dirty eviction", 1'b0, 26'h3FFFFFF, 2'd1, 4'h8);
        do_req("R6 clean eviction", 1'b1, 26'h7, 2'd1, 4'h7);
        do_req("R11 back-to-back same set", 1'b0, 26'h7, 2'd1, 4'h7);
        do_req("R8 other set same tag", 1'b0, 26'h7, 2'd2, 4'hA);

        for (int n = 0; n < 1500; n++) begin
            do_req("R11 random", 1'($urandom), TAG_W'($urandom_range(0, 5)),
                   IDX_W'($urandom), OFF_W'($urandom));
        end
        finish_run();
    end
endmodule